// File: doc/BRIEF.md
# Deadline-Aware Time-Slotted Memory Arbiter

This block decides, cycle by cycle, which requestor may issue commands to a DRAM controller. Time is cut into a repeating frame of equal-length slots. Each critical requestor owns exactly one slot: the slot whose number equals its ID. Non-critical requestors own no slot. Slot time that the owner does not use, or that a holder has released, is refilled by picking the pending requestor with the earliest deadline.

Each cycle the block receives one pending flag per requestor and one unsigned deadline counter per requestor, packed into a single vector. It also receives a flag saying that the command issued in this cycle is a column access. A grant is released by that column access. At the first cycle of a slot, the slot owner may take the grant away from the current holder when the owner's deadline is within one slot length. The block reports the current slot index, the cycle offset inside the slot and the registered grant (a valid bit and an ID). A decision taken in cycle t is visible in cycle t+1.

Top module: `tdm_deadline_arbiter`

## Requirements
- R1: The in-slot cycle counter counts 0, 1, …, SLOT_LEN-1 and then returns to 0, advancing once per clock.
- R2: The slot index changes only on the edge where the cycle counter wraps. It then advances by one, and from SLOTS-1 it returns to 0.
- R3: A synchronous active-high reset sets the slot index and the cycle counter to 0 and clears the grant (valid 0, ID 0).
- R4: With no grant held and no requestor pending, the grant stays invalid in the next cycle.
- R5: With no grant held and at least one requestor pending, in any cycle the next grant is the earliest-deadline pick defined in R6 and R7.
- R6: The earliest-deadline pick considers only pending requestors. It is the one with the numerically smallest deadline, and among equal deadlines the lowest ID wins.
- R7: Requestors with ID below SLOTS are critical. When any pending critical requestor has a deadline <= SLOT_LEN, the pick is the lowest-ID such critical requestor, whatever the deadlines of the others.
- R8: In a cycle whose counter is not 0, a held grant is kept unchanged in the next cycle when no column access is issued.
- R9: In a cycle whose counter is not 0, a held grant is cleared in the next cycle when a column access is issued.
- R10: In a cycle whose counter is 0 with a grant held, if the owner of the current slot is pending with deadline <= SLOT_LEN, the next grant goes to that owner, even when a column access is issued.
- R11: In a cycle whose counter is 0 with a grant held and no preemption under R10, the next grant is cleared if a column access is issued. Otherwise it is re-decided by the pick of R6 and R7.
- R12: While the grant is invalid the grant ID output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_pending | input | NREQ | One pending flag per requestor, bit i for ID i |
| req_deadline | input | NREQ*DL_W | Deadline of requestor i in bits [i*DL_W +: DL_W] |
| cmd_is_cas | input | 1 | Command issued this cycle is a column access |
| slot_idx | output | SLOT_W | Current slot number |
| slot_cycle | output | CYC_W | Cycle offset within the slot |
| grant_valid | output | 1 | A requestor holds the grant |
| grant_id | output | ID_W | ID of the holder, 0 when invalid |

## Verification
The bench goes after the cycle with counter 0. At that cycle three rules compete: owner preemption, release by column access and re-selection. A design that ranked them wrongly would let a column access beat an urgent owner, or keep a holder past the boundary instead of re-deciding. Deadline ties and critical requestors at exactly SLOT_LEN are driven on purpose. A design with a non-strict comparison would hand ties to the highest ID, and one that ignored the urgency lock would grant a non-critical requestor with a smaller deadline. Long stretches without column accesses show whether a mid-slot holder is kept. Idle stretches show whether a grant appears from nothing. A mid-run reset shows whether the frame restarts at slot 0.

// File: rtl/tdm_arb_pkg.sv
package tdm_arb_pkg;

    // Next-grant decision taken by the grant controller.
    typedef enum logic [1:0] {
        DEC_KEEP  = 2'd0,
        DEC_CLEAR = 2'd1,
        DEC_OWNER = 2'd2,
        DEC_PICK  = 2'd3
    } grant_dec_e;

    // Width of an index field, never below one bit.
    function automatic int unsigned idx_width(input int unsigned count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

    // True when a deadline lies within one slot length.
    function automatic logic within_slot(input logic [31:0] dl, input int unsigned slot_len);
        return dl <= slot_len;
    endfunction

endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
    import tdm_arb_pkg::*;
#(
    parameter int unsigned SLOTS    = 4,
    parameter int unsigned SLOT_LEN = 27,
    parameter int unsigned SLOT_W   = idx_width(SLOTS),
    parameter int unsigned CYC_W    = idx_width(SLOT_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    output logic [SLOT_W-1:0] slot_o,
    output logic [CYC_W-1:0]  cycle_o,
    output logic              slot_start_o
);

    localparam logic [CYC_W-1:0]  LAST_CYC  = CYC_W'(SLOT_LEN - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    logic wrap;

    assign wrap         = (cycle_o == LAST_CYC);
    assign slot_start_o = (cycle_o == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cycle_o <= '0;
            slot_o  <= '0;
        end else begin
            cycle_o <= wrap ? '0 : cycle_o + 1'b1;
            if (wrap) begin
                slot_o <= (slot_o == LAST_SLOT) ? '0 : slot_o + 1'b1;
            end
        end
    end

    assert_cycle_range_R1: assert property (@(posedge clk) disable iff (rst)
        32'(cycle_o) < SLOT_LEN);
    assert_cycle_step_R1: assert property (@(posedge clk) disable iff (rst)
        (cycle_o != LAST_CYC) |=> (cycle_o == $past(cycle_o) + 1'b1));
    assert_slot_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (cycle_o != LAST_CYC) |=> $stable(slot_o));
    assert_slot_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (cycle_o == LAST_CYC && slot_o == LAST_SLOT) |=> (slot_o == '0));

endmodule

// File: rtl/tdm_edf_picker.sv
module tdm_edf_picker
    import tdm_arb_pkg::*;
#(
    parameter int unsigned SLOTS    = 4,
    parameter int unsigned NREQ     = 6,
    parameter int unsigned SLOT_LEN = 27,
    parameter int unsigned DL_W     = 8,
    parameter int unsigned ID_W     = idx_width(NREQ)
) (
    input  logic [NREQ-1:0]      pending_i,
    input  logic [NREQ*DL_W-1:0] deadline_i,
    output logic                 pick_valid_o,
    output logic [ID_W-1:0]      pick_id_o
);

    logic [DL_W-1:0] best_dl;
    logic            best_locked;

    // Ascending scan: replace only on a strictly smaller deadline; an
    // urgent critical candidate, once held, is never displaced.
    always_comb begin
        pick_valid_o = 1'b0;
        pick_id_o    = '0;
        best_dl      = '0;
        best_locked  = 1'b0;
        for (int i = 0; i < int'(NREQ); i++) begin
            logic [DL_W-1:0] dl;
            logic            urgent_crit;
            dl          = deadline_i[i*DL_W +: DL_W];
            urgent_crit = (i < int'(SLOTS)) && within_slot(32'(dl), SLOT_LEN);
            if (pending_i[i]) begin
                if (!pick_valid_o || (!best_locked && dl < best_dl)) begin
                    pick_valid_o = 1'b1;
                    pick_id_o    = ID_W'(i);
                    best_dl      = dl;
                    best_locked  = urgent_crit;
                end
            end
        end
    end

    always_comb begin
        if (pick_valid_o) begin
            assert_pick_pending_R6: assert (pending_i[pick_id_o]);
        end
    end

endmodule

// File: rtl/tdm_grant_ctrl.sv
module tdm_grant_ctrl
    import tdm_arb_pkg::*;
#(
    parameter int unsigned SLOTS    = 4,
    parameter int unsigned NREQ     = 6,
    parameter int unsigned SLOT_LEN = 27,
    parameter int unsigned DL_W     = 8,
    parameter int unsigned SLOT_W   = idx_width(SLOTS),
    parameter int unsigned ID_W     = idx_width(NREQ)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SLOT_W-1:0]    slot_i,
    input  logic                 slot_start_i,
    input  logic [NREQ-1:0]      pending_i,
    input  logic [NREQ*DL_W-1:0] deadline_i,
    input  logic                 cas_i,
    input  logic                 pick_valid_i,
    input  logic [ID_W-1:0]      pick_id_i,
    output logic                 grant_valid_o,
    output logic [ID_W-1:0]      grant_id_o
);

    grant_dec_e      dec;
    logic            owner_pend;
    logic [DL_W-1:0] owner_dl;
    logic            owner_urgent;

    assign owner_pend   = pending_i[slot_i];
    assign owner_dl     = deadline_i[int'(slot_i)*DL_W +: DL_W];
    assign owner_urgent = owner_pend && within_slot(32'(owner_dl), SLOT_LEN);

    always_comb begin
        if (!grant_valid_o) begin
            dec = DEC_PICK;
        end else if (slot_start_i && owner_urgent) begin
            dec = DEC_OWNER;
        end else if (cas_i) begin
            dec = DEC_CLEAR;
        end else if (slot_start_i) begin
            dec = DEC_PICK;
        end else begin
            dec = DEC_KEEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_valid_o <= 1'b0;
            grant_id_o    <= '0;
        end else begin
            unique case (dec)
                DEC_OWNER: begin
                    grant_valid_o <= 1'b1;
                    grant_id_o    <= ID_W'(slot_i);
                end
                DEC_CLEAR: begin
                    grant_valid_o <= 1'b0;
                    grant_id_o    <= '0;
                end
                DEC_PICK: begin
                    grant_valid_o <= pick_valid_i;
                    grant_id_o    <= pick_valid_i ? pick_id_i : '0;
                end
                default: begin
                    grant_valid_o <= grant_valid_o;
                    grant_id_o    <= grant_id_o;
                end
            endcase
        end
    end

    assert_reset_R3: assert property (@(posedge clk)
        rst |=> (!grant_valid_o && grant_id_o == '0));
    assert_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (!grant_valid_o && pending_i == '0) |=> !grant_valid_o);
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (grant_valid_o && !slot_start_i && !cas_i) |=> (grant_valid_o && $stable(grant_id_o)));
    assert_release_R9: assert property (@(posedge clk) disable iff (rst)
        (grant_valid_o && !slot_start_i && cas_i) |=> !grant_valid_o);
    assert_preempt_R10: assert property (@(posedge clk) disable iff (rst)
        (grant_valid_o && slot_start_i && owner_urgent)
            |=> (grant_valid_o && 32'(grant_id_o) == 32'($past(slot_i))));
    assert_idle_id_R12: assert property (@(posedge clk) disable iff (rst)
        !grant_valid_o |-> (grant_id_o == '0));

endmodule

// File: rtl/tdm_deadline_arbiter.sv
module tdm_deadline_arbiter
    import tdm_arb_pkg::*;
#(
    parameter int unsigned SLOTS    = 4,
    parameter int unsigned NREQ     = 6,
    parameter int unsigned SLOT_LEN = 27,
    parameter int unsigned DL_W     = 8,
    parameter int unsigned SLOT_W   = idx_width(SLOTS),
    parameter int unsigned CYC_W    = idx_width(SLOT_LEN),
    parameter int unsigned ID_W     = idx_width(NREQ)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NREQ-1:0]      req_pending,
    input  logic [NREQ*DL_W-1:0] req_deadline,
    input  logic                 cmd_is_cas,
    output logic [SLOT_W-1:0]    slot_idx,
    output logic [CYC_W-1:0]     slot_cycle,
    output logic                 grant_valid,
    output logic [ID_W-1:0]      grant_id
);

    logic            slot_start;
    logic            pick_valid;
    logic [ID_W-1:0] pick_id;

    initial begin
        assert_cfg_R2: assert (SLOTS > 1 && NREQ >= SLOTS && SLOT_LEN > 1);
    end

    tdm_frame_timer #(
        .SLOTS(SLOTS), .SLOT_LEN(SLOT_LEN), .SLOT_W(SLOT_W), .CYC_W(CYC_W)
    ) u_timer (
        .clk(clk), .rst(rst),
        .slot_o(slot_idx), .cycle_o(slot_cycle), .slot_start_o(slot_start)
    );

    tdm_edf_picker #(
        .SLOTS(SLOTS), .NREQ(NREQ), .SLOT_LEN(SLOT_LEN), .DL_W(DL_W), .ID_W(ID_W)
    ) u_picker (
        .pending_i(req_pending), .deadline_i(req_deadline),
        .pick_valid_o(pick_valid), .pick_id_o(pick_id)
    );

    tdm_grant_ctrl #(
        .SLOTS(SLOTS), .NREQ(NREQ), .SLOT_LEN(SLOT_LEN), .DL_W(DL_W),
        .SLOT_W(SLOT_W), .ID_W(ID_W)
    ) u_grant (
        .clk(clk), .rst(rst),
        .slot_i(slot_idx), .slot_start_i(slot_start),
        .pending_i(req_pending), .deadline_i(req_deadline), .cas_i(cmd_is_cas),
        .pick_valid_i(pick_valid), .pick_id_i(pick_id),
        .grant_valid_o(grant_valid), .grant_id_o(grant_id)
    );

endmodule

// File: tb/tdm_deadline_arbiter_bench.sv
module tdm_deadline_arbiter_bench;

    localparam int SLOTS = 4;
    localparam int NREQ  = 6;
    localparam int SL    = 27;
    localparam int DL_W  = 8;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int CYC_W  = $clog2(SL);
    localparam int ID_W   = $clog2(NREQ);

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NREQ-1:0]      pend = '0;
    logic [NREQ*DL_W-1:0] dls = '0;
    logic                 cas = 1'b0;
    logic [SLOT_W-1:0]    slot_idx;
    logic [CYC_W-1:0]     slot_cycle;
    logic                 grant_valid;
    logic [ID_W-1:0]      grant_id;

    int checks = 0;
    int errors = 0;
    int dl_arr [NREQ];

    // Reference state
    int    m_slot = 0, m_cyc = 0, m_gv = 0, m_gid = 0;
    string m_rule = "R3";

    always #5 clk = ~clk;

    tdm_deadline_arbiter #(
        .SLOTS(SLOTS), .NREQ(NREQ), .SLOT_LEN(SL), .DL_W(DL_W)
    ) u_tdm_deadline_arbiter (
        .clk(clk), .rst(rst), .req_pending(pend), .req_deadline(dls),
        .cmd_is_cas(cas), .slot_idx(slot_idx), .slot_cycle(slot_cycle),
        .grant_valid(grant_valid), .grant_id(grant_id)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic apply_inputs(input logic [NREQ-1:0] p, input logic c);
        pend = p;
        cas  = c;
        for (int i = 0; i < NREQ; i++) dls[i*DL_W +: DL_W] = DL_W'(dl_arr[i]);
    endtask

    // Urgent critical first (R7), otherwise smallest deadline, lowest ID (R6).
    task automatic ref_pick(output int v, output int id, output string rule);
        v = 0; id = 0; rule = "R6";
        for (int c = 0; c < SLOTS; c++) begin
            if (pend[c] && dl_arr[c] <= SL) begin
                v = 1; id = c; rule = "R7";
                return;
            end
        end
        for (int i = 0; i < NREQ; i++) begin
            if (pend[i] && (v == 0 || dl_arr[i] < dl_arr[id])) begin
                v = 1; id = i;
            end
        end
    endtask

    task automatic model_step();
        int pv, pid;
        string prule;
        int owner_urg;
        if (rst) begin
            m_slot = 0; m_cyc = 0; m_gv = 0; m_gid = 0; m_rule = "R3";
            return;
        end
        ref_pick(pv, pid, prule);
        owner_urg = pend[m_slot] && dl_arr[m_slot] <= SL;
        if (m_gv == 0) begin
            m_gv = pv; m_gid = pv ? pid : 0;
            m_rule = pv ? {"R5/", prule} : "R4";
        end else if (m_cyc == 0 && owner_urg) begin
            m_gid = m_slot; m_rule = "R10";
        end else if (cas) begin
            m_gv = 0; m_gid = 0;
            m_rule = (m_cyc == 0) ? "R11" : "R9";
        end else if (m_cyc == 0) begin
            m_gv = pv; m_gid = pv ? pid : 0;
            m_rule = {"R11/", prule};
        end else begin
            m_rule = "R8";
        end
        if (m_cyc == SL - 1) begin
            m_cyc = 0;
            m_slot = (m_slot == SLOTS - 1) ? 0 : m_slot + 1;
        end else begin
            m_cyc++;
        end
    endtask

    task automatic compare();
        chk("R1", int'(slot_cycle), m_cyc);
        chk("R2", int'(slot_idx), m_slot);
        chk(m_rule, int'(grant_valid), m_gv);
        chk((m_gv == 0) ? "R12" : m_rule, int'(grant_id), m_gid);
    endtask

    // One cycle: check at negedge, drive new inputs, advance the model.
    task automatic cycle(input logic r, input logic [NREQ-1:0] p, input logic c);
        @(negedge clk);
        compare();
        rst = r;
        apply_inputs(p, c);
        model_step();
    endtask

    task automatic rand_dl(input int span);
        for (int i = 0; i < NREQ; i++) dl_arr[i] = int'($urandom_range(span));
    endtask

    initial begin
        for (int i = 0; i < NREQ; i++) dl_arr[i] = 100;
        // Reset (R3)
        for (int k = 0; k < 3; k++) cycle(1'b1, '0, 1'b0);
        // Idle: nothing pending (R4)
        for (int k = 0; k < 60; k++) cycle(1'b0, '0, k[0]);
        // Equal deadlines, non-urgent: ties go to lowest ID (R6)
        for (int i = 0; i < NREQ; i++) dl_arr[i] = 40;
        for (int k = 0; k < 120; k++) cycle(1'b0, NREQ'($urandom), ($urandom_range(7) == 0));
        // Non-critical with small deadline vs critical exactly at SL (R7)
        for (int k = 0; k < 120; k++) begin
            dl_arr[4] = 1; dl_arr[5] = 0; dl_arr[2] = SL; dl_arr[3] = SL - 1;
            dl_arr[0] = 90; dl_arr[1] = 60;
            cycle(1'b0, NREQ'($urandom), ($urandom_range(5) == 0));
        end
        // Long hold without column access (R8)
        rand_dl(200);
        for (int k = 0; k < 150; k++) cycle(1'b0, NREQ'($urandom) | 6'b110000, 1'b0);
        // Urgent owners with column accesses at boundaries (R10, R11)
        for (int k = 0; k < 800; k++) begin
            rand_dl(45);
            cycle(1'b0, NREQ'($urandom), ($urandom_range(2) == 0));
        end
        // Mid-run reset (R3)
        for (int k = 0; k < 2; k++) cycle(1'b1, '1, 1'b0);
        // General random traffic
        for (int k = 0; k < 2500; k++) begin
            rand_dl(70);
            cycle(1'b0, NREQ'($urandom), ($urandom_range(4) == 0));
        end
        @(negedge clk);
        compare();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule